// File: doc/BRIEF.md
# Serial Memory Slave for a Two-Wire Bus

This block is the protocol engine of a byte-addressed serial memory. It sits on a two-wire I2C bus as a slave. The system clock samples SCL and SDA, which are much slower than that clock. The block drives SDA only by pulling it low. It holds the memory array, a one-page write buffer and the persistent address pointer.

A bus master writes one byte or a run of bytes within one page. Each write opens with a two-byte address. The buffered bytes are committed to the array only when a STOP closes the write. For a fixed number of clock cycles after that STOP, the slave stays silent on its own address, so the master can poll it until the write has finished. The master can read from the current pointer, or first load the pointer with an address-only write followed by a repeated START. A read can stream through the whole array, and the pointer wraps from the end of the array back to zero. A write-lock input, sampled just before the first data byte, can reject a write. Three strap inputs let up to eight such slaves share one bus.

Top module: `serial_mem_slave`

## Requirements
- R1: The slave acknowledges a header byte only when its upper seven bits equal binary 1010 followed by `dev_sel[2:0]` (bit 2 first). Bit 0 selects read (1) or write (0). Any other header is not acknowledged, and the slave then ignores the bus until the next START.
- R2: SDA falling while SCL is high is a START, and SDA rising while SCL is high is a STOP. Data bits are taken on SCL rising. The slave changes `sda_pull` only after SCL has fallen, never while SCL stays high.
- R3: In a write, the slave acknowledges the header, the address high byte, the address low byte and every data byte. Each acknowledge holds SDA low for the 9th clock. A byte written this way reads back unchanged after the write completes.
- R4: A page is 128 bytes. The address bits above the low 7 select the page. Each data byte after the first advances only the low 7 bits, so byte 129 of a run lands on the first byte's offset and overwrites it.
- R5: The buffered data reaches the array only on a STOP that follows a complete data byte. For WRITE_CYCLES clocks after that STOP, the slave does not acknowledge its own header for either direction.
- R6: `wr_lock` is sampled on the SCL falling edge that ends the address-low acknowledge. If it is high, the first data byte is not acknowledged, the array is left unchanged and no busy window starts.
- R7: The pointer persists between transactions. It points just past the last byte read or written, and it wraps from DEPTH-1 to 0.
- R8: A read header with no address phase returns the byte at the pointer. An address-only write followed by a repeated START and a read header returns the byte at the given address.
- R9: While sending, the slave releases SDA in the 9th clock. A master acknowledge makes it send the next byte. A master no-acknowledge makes it leave SDA released until the next START or STOP.
- R10: A START or STOP that arrives inside a data byte of a write discards the buffered bytes, and no busy window starts.
- R11: Only the page offsets that received a byte change on commit. An address-only write closed by STOP or by a repeated START changes nothing and starts no busy window.
- R12: Reset fills the array with 0xFF, sets the pointer to 0, releases SDA and leaves the slave not busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous reset, active low |
| scl_in | input | 1 | Bus clock level |
| sda_in | input | 1 | Bus data level (wired-AND of all drivers) |
| sda_pull | output | 1 | 1 pulls SDA low; 0 releases it |
| dev_sel | input | 3 | Strap bits of the slave address |
| wr_lock | input | 1 | Write lock; high rejects writes |

## Verification
Single-byte writes are spread over all four pages, including the first and last addresses. Each is read back by address, which separates page selection from offset handling. A 130-byte run across a page boundary shows in-page wrap, because the wrapped bytes replace earlier ones while the next page keeps 0xFF. A two-byte run beside an already written byte shows that unloaded offsets survive. Polling right after a STOP, and after a locked write, an aborted write and an address-only write, separates a real commit from a discarded buffer. Reads by pointer, across the array end, and after a reset separate the pointer's persistence from its wrap.

// File: rtl/seme_pkg.sv
package seme_pkg;
    // Fixed upper nibble of the slave header
    localparam logic [3:0] DEV_PREFIX = 4'b1010;

    // Transaction phase of the protocol engine
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_DEV,
        PH_AHI,
        PH_ALO,
        PH_WDAT,
        PH_RDAT,
        PH_IGN
    } phase_t;
endpackage

// File: rtl/smb_sense.sv
// Bus front end: resynchronises SCL, SDA and the write lock to clk and
// derives edge and START/STOP strobes. Assumes SCL and SDA pass through the
// same number of stages, so that their relative order is preserved.
module smb_sense #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    input  logic wp_in,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic wp_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam logic [2:0] IDLE_BUS = 3'b011;

    logic [2:0] pipe [STAGES];
    logic [2:0] prev;
    logic [2:0] cur;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                // first stage takes the raw pins
                always_ff @(posedge clk) begin
                    if (!rst_n) pipe[0] <= IDLE_BUS;
                    else        pipe[0] <= {wp_in, sda_in, scl_in};
                end
            end else begin : g_next
                // later stages shift the sample along
                always_ff @(posedge clk) begin
                    if (!rst_n) pipe[g] <= IDLE_BUS;
                    else        pipe[g] <= pipe[g-1];
                end
            end
        end
    endgenerate

    // one-cycle history for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= IDLE_BUS;
        else        prev <= cur;
    end

    assign cur       = pipe[STAGES-1];
    assign scl_lvl   = cur[0];
    assign sda_lvl   = cur[1];
    assign wp_lvl    = cur[2];
    assign scl_rise  = cur[0] & ~prev[0];
    assign scl_fall  = ~cur[0] & prev[0];
    assign start_det = cur[0] & prev[0] & prev[1] & ~cur[1];
    assign stop_det  = cur[0] & prev[0] & ~prev[1] & cur[1];
endmodule

// File: rtl/smb_page_buf.sv
// One-page write buffer. Each offset carries a loaded flag, so that commit
// touches only the bytes the master sent. A clear drops every flag.
module smb_page_buf #(
    parameter int PAGE_BYTES = 128,
    parameter int PW         = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          we,
    input  logic [PW-1:0] widx,
    input  logic [7:0]    wdata,
    input  logic [PW-1:0] ridx,
    output logic          rvld,
    output logic [7:0]    rdata
);
    logic [PAGE_BYTES-1:0] vld;
    logic [7:0]            dat [PAGE_BYTES];

    // loaded flags: clear wins over load
    always_ff @(posedge clk) begin
        if (!rst_n || clr) vld <= '0;
        else if (we)       vld[widx] <= 1'b1;
    end

    // byte storage, no reset needed behind the flags
    always_ff @(posedge clk) begin
        if (we) dat[widx] <= wdata;
    end

    assign rvld  = vld[ridx];
    assign rdata = dat[ridx];
endmodule

// File: rtl/smb_commit.sv
// Write-cycle timer. On a go strobe it walks the page buffer for the first
// PAGE_BYTES cycles, writing the loaded offsets into the array, and stays busy
// for WRITE_CYCLES cycles in total. Assumes WRITE_CYCLES >= PAGE_BYTES.
module smb_commit #(
    parameter int AW           = 9,
    parameter int PW           = 7,
    parameter int PAGE_BYTES   = 128,
    parameter int WRITE_CYCLES = 400
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [AW-PW-1:0] page,
    input  logic             bvld,
    input  logic [7:0]       bdata,
    output logic             busy,
    output logic             done,
    output logic [PW-1:0]    ridx,
    output logic             mem_we,
    output logic [AW-1:0]    mem_waddr,
    output logic [7:0]       mem_wdata
);
    localparam int CW = $clog2(WRITE_CYCLES + 1);

    logic [CW-1:0]    cnt;
    logic [AW-PW-1:0] page_q;
    logic             walking;

    // busy window counter with latched target page
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            cnt    <= '0;
            page_q <= '0;
        end else if (go && !busy) begin
            busy   <= 1'b1;
            cnt    <= '0;
            page_q <= page;
        end else if (busy) begin
            if (done) busy <= 1'b0;
            else      cnt  <= cnt + 1'b1;
        end
    end

    assign done      = busy && (cnt == CW'(WRITE_CYCLES - 1));
    assign walking   = busy && (cnt < CW'(PAGE_BYTES));
    assign ridx      = cnt[PW-1:0];
    assign mem_we    = walking && bvld;
    assign mem_waddr = {page_q, ridx};
    assign mem_wdata = bdata;
endmodule

// File: rtl/smb_mem.sv
// Storage array with one write port and a registered read port. Reset
// puts every byte at 0xFF, the erased value.
module smb_mem #(
    parameter int DEPTH = 512,
    parameter int AW    = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] cells [DEPTH];

    // erase on reset, otherwise write and read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) cells[i] <= 8'hFF;
            rdata <= 8'hFF;
        end else begin
            if (we) cells[waddr] <= wdata;
            rdata <= cells[raddr];
        end
    end
endmodule

// File: rtl/smb_ctrl.sv
// Protocol engine: header match, address phase, data receive into the page
// buffer, data transmit from the array and acknowledge handling. Works on
// the strobes from smb_sense. It assumes the array's registered read port has
// settled on the pointer long before the SCL edge that consumes it.
module smb_ctrl
    import seme_pkg::*;
#(
    parameter int AW = 9,
    parameter int PW = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_rise,
    input  logic             scl_fall,
    input  logic             start_det,
    input  logic             stop_det,
    input  logic             sda_lvl,
    input  logic             wp_lvl,
    input  logic             busy,
    input  logic [2:0]       dev_sel,
    input  logic [7:0]       mem_rdata,
    output logic [AW-1:0]    mem_raddr,
    output logic             sda_pull,
    output logic             buf_we,
    output logic             buf_clr,
    output logic             commit_go,
    output logic [PW-1:0]    buf_idx,
    output logic [7:0]       buf_wdata,
    output logic [AW-PW-1:0] commit_page,
    output phase_t           phase
);
    logic [3:0]    bit_cnt;
    logic          ack_ph, dec_ok, rw_q, wp_hit, m_ack, loaded;
    logic [7:0]    sr, ahi_q;
    logic [AW-1:0] ptr;
    logic          rx_ph, hit;
    logic [15:0]   addr_full;

    assign rx_ph       = (phase == PH_DEV) || (phase == PH_AHI) ||
                         (phase == PH_ALO) || (phase == PH_WDAT);
    assign hit         = (sr[7:1] == {DEV_PREFIX, dev_sel}) && !busy;
    assign addr_full   = {ahi_q, sr};
    assign mem_raddr   = ptr;
    assign commit_page = ptr[AW-1:PW];

    // bus transaction sequencer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= PH_IDLE;
            bit_cnt   <= '0;
            ack_ph    <= 1'b0;
            dec_ok    <= 1'b0;
            rw_q      <= 1'b0;
            wp_hit    <= 1'b0;
            m_ack     <= 1'b0;
            loaded    <= 1'b0;
            sr        <= '0;
            ahi_q     <= '0;
            ptr       <= '0;
            sda_pull  <= 1'b0;
            buf_we    <= 1'b0;
            buf_clr   <= 1'b0;
            commit_go <= 1'b0;
            buf_idx   <= '0;
            buf_wdata <= '0;
        end else begin
            buf_we    <= 1'b0;
            buf_clr   <= 1'b0;
            commit_go <= 1'b0;
            if (start_det) begin
                phase    <= PH_DEV;
                bit_cnt  <= '0;
                ack_ph   <= 1'b0;
                sda_pull <= 1'b0;
                loaded   <= 1'b0;
                if (!busy) buf_clr <= 1'b1;
            end else if (stop_det) begin
                if (phase == PH_WDAT && !ack_ph && bit_cnt == 4'd1 && loaded)
                    commit_go <= 1'b1;
                else if (!busy)
                    buf_clr <= 1'b1;
                phase    <= PH_IDLE;
                bit_cnt  <= '0;
                ack_ph   <= 1'b0;
                sda_pull <= 1'b0;
                loaded   <= 1'b0;
            end else if (scl_rise) begin
                if (ack_ph) begin
                    if (phase == PH_RDAT) m_ack <= ~sda_lvl;
                end else if (rx_ph && bit_cnt < 4'd8) begin
                    sr      <= {sr[6:0], sda_lvl};
                    bit_cnt <= bit_cnt + 4'd1;
                end
            end else if (scl_fall) begin
                if (ack_ph) begin
                    ack_ph   <= 1'b0;
                    sda_pull <= 1'b0;
                    bit_cnt  <= '0;
                    if (!dec_ok) begin
                        phase <= PH_IGN;
                    end else begin
                        case (phase)
                            PH_DEV: begin
                                if (rw_q) begin
                                    phase    <= PH_RDAT;
                                    sr       <= mem_rdata;
                                    sda_pull <= ~mem_rdata[7];
                                    ptr      <= ptr + 1'b1;
                                    bit_cnt  <= 4'd1;
                                end else begin
                                    phase <= PH_AHI;
                                end
                            end
                            PH_AHI: phase <= PH_ALO;
                            PH_ALO: begin
                                phase  <= PH_WDAT;
                                wp_hit <= wp_lvl;
                            end
                            PH_RDAT: begin
                                if (m_ack) begin
                                    sr       <= mem_rdata;
                                    sda_pull <= ~mem_rdata[7];
                                    ptr      <= ptr + 1'b1;
                                    bit_cnt  <= 4'd1;
                                end else begin
                                    phase <= PH_IGN;
                                end
                            end
                            default: ;
                        endcase
                    end
                end else if (phase == PH_RDAT) begin
                    if (bit_cnt < 4'd8) begin
                        sda_pull <= ~sr[6];
                        sr       <= {sr[6:0], 1'b0};
                        bit_cnt  <= bit_cnt + 4'd1;
                    end else begin
                        sda_pull <= 1'b0;
                        ack_ph   <= 1'b1;
                        dec_ok   <= 1'b1;
                    end
                end else if (rx_ph && bit_cnt == 4'd8) begin
                    ack_ph <= 1'b1;
                    case (phase)
                        PH_DEV: begin
                            dec_ok   <= hit;
                            sda_pull <= hit;
                            rw_q     <= sr[0];
                        end
                        PH_AHI: begin
                            dec_ok   <= 1'b1;
                            sda_pull <= 1'b1;
                            ahi_q    <= sr;
                        end
                        PH_ALO: begin
                            dec_ok   <= 1'b1;
                            sda_pull <= 1'b1;
                            ptr      <= addr_full[AW-1:0];
                        end
                        default: begin
                            if (wp_hit) begin
                                dec_ok   <= 1'b0;
                                sda_pull <= 1'b0;
                            end else begin
                                dec_ok    <= 1'b1;
                                sda_pull  <= 1'b1;
                                buf_we    <= 1'b1;
                                buf_idx   <= ptr[PW-1:0];
                                buf_wdata <= sr;
                                ptr       <= {ptr[AW-1:PW], ptr[PW-1:0] + 1'b1};
                                loaded    <= 1'b1;
                            end
                        end
                    endcase
                end
            end
        end
    end
endmodule

// File: rtl/serial_mem_slave.sv
// Top level of the serial memory slave. Joins the bus front end, the protocol
// engine, the page buffer, the write-cycle timer and the array. Assumes
// DEPTH and PAGE_BYTES are powers of two, DEPTH > PAGE_BYTES, DEPTH <= 65536
// and WRITE_CYCLES >= PAGE_BYTES.
module serial_mem_slave
    import seme_pkg::*;
#(
    parameter int DEPTH        = 512,
    parameter int PAGE_BYTES   = 128,
    parameter int WRITE_CYCLES = 400,
    parameter int SYNC_STAGES  = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_in,
    input  logic       sda_in,
    output logic       sda_pull,
    input  logic [2:0] dev_sel,
    input  logic       wr_lock
);
    localparam int AW  = $clog2(DEPTH);
    localparam int PW  = $clog2(PAGE_BYTES);
    localparam int PGW = AW - PW;

    logic           scl_s, sda_s, wp_s;
    logic           scl_rise, scl_fall, start_det, stop_det;
    logic           busy, commit_done, commit_go;
    logic           buf_we, buf_clr, bvld;
    logic [PW-1:0]  buf_idx, ridx;
    logic [7:0]     buf_wdata, bdata;
    logic [PGW-1:0] commit_page;
    logic           mem_we;
    logic [AW-1:0]  mem_waddr, mem_raddr;
    logic [7:0]     mem_wdata, mem_rdata;
    phase_t         phase;

    smb_sense #(.STAGES(SYNC_STAGES)) u_sense (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .wp_in(wr_lock), .scl_lvl(scl_s), .sda_lvl(sda_s), .wp_lvl(wp_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    smb_ctrl #(.AW(AW), .PW(PW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det), .sda_lvl(sda_s),
        .wp_lvl(wp_s), .busy(busy), .dev_sel(dev_sel), .mem_rdata(mem_rdata),
        .mem_raddr(mem_raddr), .sda_pull(sda_pull), .buf_we(buf_we),
        .buf_clr(buf_clr), .commit_go(commit_go), .buf_idx(buf_idx),
        .buf_wdata(buf_wdata), .commit_page(commit_page), .phase(phase)
    );

    smb_page_buf #(.PAGE_BYTES(PAGE_BYTES), .PW(PW)) u_buf (
        .clk(clk), .rst_n(rst_n), .clr(buf_clr | commit_done), .we(buf_we),
        .widx(buf_idx), .wdata(buf_wdata), .ridx(ridx), .rvld(bvld),
        .rdata(bdata)
    );

    smb_commit #(.AW(AW), .PW(PW), .PAGE_BYTES(PAGE_BYTES),
                 .WRITE_CYCLES(WRITE_CYCLES)) u_commit (
        .clk(clk), .rst_n(rst_n), .go(commit_go), .page(commit_page),
        .bvld(bvld), .bdata(bdata), .busy(busy), .done(commit_done),
        .ridx(ridx), .mem_we(mem_we), .mem_waddr(mem_waddr),
        .mem_wdata(mem_wdata)
    );

    smb_mem #(.DEPTH(DEPTH), .AW(AW)) u_mem (
        .clk(clk), .rst_n(rst_n), .we(mem_we), .waddr(mem_waddr),
        .wdata(mem_wdata), .raddr(mem_raddr), .rdata(mem_rdata)
    );
endmodule

// File: rtl/serial_mem_slave_chk.sv
// Property checker for serial_mem_slave, attached by bind. It watches the
// synchronised clock level, the SDA pull, the busy window and the write ports.
module serial_mem_slave_chk
    import seme_pkg::*;
(
    input logic   clk,
    input logic   rst_n,
    input logic   scl_s,
    input logic   sda_pull,
    input logic   busy,
    input logic   mem_we,
    input logic   buf_we,
    input logic   start_det,
    input phase_t phase
);
    AST_PULL_HOLD_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_s && $past(scl_s)) |-> $stable(sda_pull)); // R2
    AST_START_OPENS_HEADER: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (phase == PH_DEV)); // R2
    AST_BUSY_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !sda_pull); // R5
    AST_ARRAY_WRITE_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy); // R5
    AST_NO_LOAD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        buf_we |-> !busy); // R11
endmodule

bind serial_mem_slave serial_mem_slave_chk u_chk (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_pull(sda_pull),
    .busy(busy), .mem_we(mem_we), .buf_we(buf_we), .start_det(start_det),
    .phase(phase)
);

// File: tb/sim_serial_mem_slave.sv
module sim_serial_mem_slave;
    localparam int Q = 8;
    localparam logic [2:0] STRAP = 3'b101;
    localparam logic [7:0] HDR_W = {4'b1010, STRAP, 1'b0};
    localparam logic [7:0] HDR_R = {4'b1010, STRAP, 1'b1};
    // {address, data} pairs for single-byte writes
    localparam logic [23:0] VEC [8] = '{
        24'h0000C3, 24'h001011, 24'h01FF5A, 24'h01239D,
        24'h004000, 24'h00A7E1, 24'h000577, 24'h01803C
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic wr_lock = 1'b0;
    logic sda_pull;
    wire  sda_line = sda_m & ~sda_pull;
    int   n_chk = 0;
    int   n_bad = 0;

    always #4 clk = ~clk;

    serial_mem_slave u0 (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line),
        .sda_pull(sda_pull), .dev_sel(STRAP), .wr_lock(wr_lock)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
    endtask

    task automatic put_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            sda_m = b[i]; wq(); scl_m = 1'b1; wq(); scl_m = 1'b0; wq();
        end
    endtask

    task automatic put_byte(input logic [7:0] b, output logic ack);
        put_bits(b, 8);
        sda_m = 1'b1; wq(); scl_m = 1'b1;
        repeat (Q / 2) @(negedge clk);
        ack = ~sda_line;
        repeat (Q / 2) @(negedge clk);
        scl_m = 1'b0; wq();
    endtask

    task automatic get_byte(input logic mack, output logic [7:0] d);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wq(); scl_m = 1'b1;
            repeat (Q / 2) @(negedge clk);
            d[i] = sda_line;
            repeat (Q / 2) @(negedge clk);
            scl_m = 1'b0;
        end
        sda_m = ~mack; wq(); scl_m = 1'b1; wq(); scl_m = 1'b0; wq();
        sda_m = 1'b1;
    endtask

    task automatic addr_phase(input logic [15:0] a, output logic ok);
        logic a0, a1, a2;
        bus_start();
        put_byte(HDR_W, a0);
        put_byte(a[15:8], a1);
        put_byte(a[7:0], a2);
        ok = a0 & a1 & a2;
    endtask

    task automatic wr_run(input logic [15:0] a, input int n, input logic [7:0] seed,
                          input logic [7:0] step, output logic ok);
        logic k;
        addr_phase(a, ok);
        for (int i = 0; i < n; i++) begin
            put_byte(seed + 8'(i) * step, k);
            ok &= k;
        end
        bus_stop();
    endtask

    task automatic poll(output int tries);
        logic k;
        tries = 0;
        do begin
            bus_start(); put_byte(HDR_W, k); bus_stop(); tries++;
        end while (!k && tries < 50);
    endtask

    task automatic rd_rand(input logic [15:0] a, output logic [7:0] d);
        logic ok, k;
        addr_phase(a, ok);
        bus_start(); put_byte(HDR_R, k); get_byte(1'b0, d); bus_stop();
    endtask

    task automatic rd_cur(output logic [7:0] d);
        logic k;
        bus_start(); put_byte(HDR_R, k); get_byte(1'b0, d); bus_stop();
    endtask

    task automatic hdr_probe(input logic [7:0] h, output logic k);
        bus_start(); put_byte(h, k); bus_stop();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog act=running exp=finished");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] d;
        logic ok, k;
        int tries;
        repeat (10) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // reset state
        chk("R12 pull released", sda_pull, 1'b0);
        rd_cur(d);      chk("R12 erased byte at pointer 0", d, 8'hFF);
        rd_rand(16'h0077, d); chk("R12 erased byte", d, 8'hFF);

        // header matching
        hdr_probe({4'b1010, 3'b100, 1'b0}, k); chk("R1 wrong strap nack", k, 1'b0);
        hdr_probe({4'b1011, STRAP, 1'b0}, k);  chk("R1 wrong prefix nack", k, 1'b0);
        hdr_probe(HDR_R, k);                   chk("R1 own read header ack", k, 1'b1);
        hdr_probe(HDR_W, k);                   chk("R1 own write header ack", k, 1'b1);

        // table walk: single-byte writes then readback
        for (int i = 0; i < 8; i++) begin
            wr_run(VEC[i][23:8], 1, VEC[i][7:0], 8'h00, ok);
            chk("R3 write acks", ok, 1'b1);
            if (i == 0) begin
                hdr_probe(HDR_R, k); chk("R5 nack during write cycle", k, 1'b0);
            end
            poll(tries);
        end
        for (int i = 0; i < 8; i++) begin
            rd_rand(VEC[i][23:8], d); chk("R8 random readback", d, VEC[i][7:0]);
        end

        // pointer persistence and sequential read across array end
        rd_rand(16'h000F, d); chk("R8 unwritten byte", d, 8'hFF);
        rd_cur(d);            chk("R7 pointer advanced", d, 8'h11);
        addr_phase(16'h01FF, ok);
        bus_start(); put_byte(HDR_R, k);
        get_byte(1'b1, d); chk("R9 first streamed byte", d, 8'h5A);
        get_byte(1'b0, d); chk("R7 wrap to address 0", d, 8'hC3);
        wq(); chk("R9 released after master nack", sda_pull, 1'b0);
        bus_stop();

        // write lock
        wr_lock = 1'b1;
        addr_phase(16'h0123, ok); put_byte(8'h00, k); bus_stop();
        chk("R6 locked data byte nack", k, 1'b0);
        wr_lock = 1'b0;
        hdr_probe(HDR_W, k); chk("R6 no busy after lock", k, 1'b1);
        rd_rand(16'h0123, d); chk("R6 array unchanged", d, 8'h9D);

        // abort inside a data byte
        addr_phase(16'h0040, ok); put_byte(8'h55, k);
        put_bits(8'hF0, 4); bus_start(); bus_stop();
        hdr_probe(HDR_W, k); chk("R10 no busy after abort", k, 1'b1);
        rd_rand(16'h0040, d); chk("R10 byte kept", d, 8'h00);

        // address-only write
        addr_phase(16'h01FF, ok); bus_stop();
        hdr_probe(HDR_W, k); chk("R11 address-only no busy", k, 1'b1);
        rd_cur(d); chk("R8 pointer loaded by address-only write", d, 8'h5A);

        // page wrap with 130 bytes starting at offset 0x7E of page 1
        wr_run(16'h00FE, 130, 8'h00, 8'h01, ok);
        chk("R3 long run acks", ok, 1'b1);
        poll(tries);
        rd_rand(16'h00FE, d); chk("R4 wrapped byte 128", d, 8'h80);
        rd_rand(16'h00FF, d); chk("R4 wrapped byte 129", d, 8'h81);
        rd_rand(16'h0080, d); chk("R4 page start", d, 8'h02);
        rd_rand(16'h00A7, d); chk("R4 overwritten", d, 8'h29);
        rd_rand(16'h0100, d); chk("R4 next page untouched", d, 8'hFF);

        // partial page: neighbours keep their value
        wr_run(16'h000E, 2, 8'hAA, 8'h11, ok);
        poll(tries);
        rd_cur(d);            chk("R7 pointer after write", d, 8'h11);
        rd_rand(16'h000E, d); chk("R11 loaded byte", d, 8'hAA);
        rd_rand(16'h000F, d); chk("R11 loaded byte 2", d, 8'hBB);
        rd_rand(16'h000D, d); chk("R11 unloaded kept", d, 8'hFF);

        // second reset erases the array
        @(negedge clk); rst_n = 1'b0;
        repeat (5) @(negedge clk); rst_n = 1'b1;
        repeat (4) @(negedge clk);
        rd_cur(d); chk("R12 array erased", d, 8'hFF);

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule